// File: doc/BRIEF.md
# Streaming IQ gain stage

This block multiplies every complex sample of a packetised stream by a gain that software programs. Samples enter on a 32-bit valid/ready payload stream and leave on a second 32-bit stream. Each sample carries signed 16-bit I in bits 31:16 and signed 16-bit Q in bits 15:0. Each component is multiplied by the unsigned gain, shifted right by a parameterised amount (zero by default) and clamped to the signed 16-bit range. The multiply runs in a two-stage pipeline. Valid, last and back-pressure travel with the data, so packet boundaries and sample order are kept exactly.

A second valid/ready stream carries the per-packet context words (header, optional time, metadata). It is wired straight from input to output with no storage, and its ready runs backwards unchanged. The gain lives in one 15-bit register at byte address 0 of a simple request/acknowledge control port. Every read or write is acknowledged one cycle later. A new gain is taken up only when the next packet starts, so every sample of a packet is scaled by the same value.

Back-pressure rules: a beat moves on an edge where tvalid and tready are both high. While the output shows tvalid without tready, its data and last stay frozen. The input tready is high whenever the pipeline can still take a beat on that edge. This includes the case where the output is being drained on the same edge.

Top module: `iq_gain_stage`

## Requirements
- R1: Each output beat carries clamp((I*g) >>> SHIFT) in bits 31:16 and clamp((Q*g) >>> SHIFT) in bits 15:0. I and Q are the signed input components, g is the packet's gain and clamp limits the value to -32768..32767. With g=0 both components are zero.
- R2: Output beats appear in input order, each exactly once, with tlast on the same beats as at the input. After the input stops, the pipeline drains completely.
- R3: While m_pl_tvalid is high and m_pl_tready is low, the output beat (valid, data, last) holds unchanged on the next cycle.
- R4: The gain register sits at control byte address 0 and holds 1 after reset. A write keeps bits 14:0 of the write data. A read returns the value zero-extended to 32 bits, as it was before any write in the same cycle.
- R5: Every control read or write, to any address, raises ctl_resp_ack for exactly one cycle on the following cycle. No ack appears without a request.
- R6: An access to any address other than 0 is acknowledged and changes nothing, and a read there returns zero.
- R7: The gain used for a packet is the register value on the cycle its first beat is accepted. A write that lands in that same cycle or later applies from the next packet on.
- R8: The context stream output equals its input on every cycle (data, last, valid), and s_cx_tready equals m_cx_tready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_req_wr | input | 1 | Control write request strobe |
| ctl_req_rd | input | 1 | Control read request strobe |
| ctl_req_addr | input | 20 | Control byte address |
| ctl_req_data | input | 32 | Control write data |
| ctl_resp_ack | output | 1 | One-cycle acknowledge |
| ctl_resp_data | output | 32 | Read data, valid with ack |
| s_pl_tdata | input | 32 | Input sample {I, Q} |
| s_pl_tlast | input | 1 | Input last beat of packet |
| s_pl_tvalid | input | 1 | Input beat valid |
| s_pl_tready | output | 1 | Input beat accepted |
| m_pl_tdata | output | 32 | Scaled sample {I, Q} |
| m_pl_tlast | output | 1 | Output last beat of packet |
| m_pl_tvalid | output | 1 | Output beat valid |
| m_pl_tready | input | 1 | Downstream ready |
| s_cx_tdata | input | 64 | Input context word |
| s_cx_tlast | input | 1 | Input context last |
| s_cx_tvalid | input | 1 | Input context valid |
| s_cx_tready | output | 1 | Context accepted |
| m_cx_tdata | output | 64 | Output context word |
| m_cx_tlast | output | 1 | Output context last |
| m_cx_tvalid | output | 1 | Output context valid |
| m_cx_tready | input | 1 | Downstream context ready |

## Verification
A gain write and the acceptance of a packet's first beat can fall in the same cycle. Separately, a write can arrive while a packet is mid-flight with the output stalled. The bench forks a control write and a packet send that start on the same edge, with the pipeline empty so the first beat is taken at once. A second case places a write a few beats into a stalled packet. A behavioural model applies the beat before the write in each cycle and checks every output beat, so the first packet must come out wholly at the old gain and the following one at the new gain.

// File: rtl/iqg_pkg.sv
package iqg_pkg;
  localparam int unsigned LANE_W = 16;
  localparam int unsigned LANES  = 2;
  localparam int unsigned BEAT_W = LANE_W * LANES;
  localparam int unsigned CSR_W  = 32;

  typedef logic signed [LANE_W-1:0]   lane_t;
  typedef logic signed [2*LANE_W-1:0] prod_t;

  // Limit a wide product to the signed lane range.
  function automatic lane_t clamp_lane(input prod_t v);
    prod_t hi;
    prod_t lo;
    hi = {{(LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
    lo = {{(LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
    if (v > hi)      return hi[LANE_W-1:0];
    else if (v < lo) return lo[LANE_W-1:0];
    else             return v[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/iqg_ctrl_regs.sv
module iqg_ctrl_regs
  import iqg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned GAIN_W     = 15,
  parameter int unsigned GAIN_ADDR  = 0,
  parameter int unsigned GAIN_RESET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CSR_W-1:0]  req_data,
  output logic              resp_ack,
  output logic [CSR_W-1:0]  resp_data,
  output logic [GAIN_W-1:0] gain_q
);
  logic hit;
  logic unused_wdata_hi;

  assign hit             = (req_addr == ADDR_W'(GAIN_ADDR));
  assign unused_wdata_hi = ^req_data[CSR_W-1:GAIN_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_ack  <= 1'b0;
      resp_data <= '0;
      gain_q    <= GAIN_W'(GAIN_RESET);
    end else begin
      resp_ack  <= req_wr | req_rd;
      resp_data <= '0;
      if (req_rd && hit) resp_data <= {{(CSR_W-GAIN_W){1'b0}}, gain_q};
      if (req_wr && hit) gain_q <= req_data[GAIN_W-1:0];
    end
  end
endmodule

// File: rtl/iqg_pkt_gain.sv
module iqg_pkt_gain #(
  parameter int unsigned GAIN_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_fire,
  input  logic              beat_last,
  input  logic [GAIN_W-1:0] reg_gain,
  output logic [GAIN_W-1:0] beat_gain
);
  logic              in_pkt_q;
  logic [GAIN_W-1:0] held_q;

  // First beat of a packet samples the register; later beats reuse it.
  assign beat_gain = in_pkt_q ? held_q : reg_gain;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt_q <= 1'b0;
      held_q   <= '0;
    end else if (beat_fire) begin
      in_pkt_q <= !beat_last;
      held_q   <= beat_gain;
    end
  end
endmodule

// File: rtl/iqg_mult_pipe.sv
module iqg_mult_pipe
  import iqg_pkg::*;
#(
  parameter int unsigned GAIN_W = 15,
  parameter int unsigned SHIFT  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BEAT_W-1:0] s_data,
  input  logic              s_last,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [GAIN_W-1:0] beat_gain,
  output logic [BEAT_W-1:0] m_data,
  output logic              m_last,
  output logic              m_valid,
  input  logic              m_ready
);
  logic  v1, l1, v2, l2;
  logic  adv1, adv2;
  lane_t gain_s;
  prod_t prod1 [LANES];
  lane_t res2  [LANES];

  assign adv2    = !v2 || m_ready;
  assign adv1    = !v1 || adv2;
  assign s_ready = adv1;
  assign gain_s  = $signed({{(LANE_W-GAIN_W){1'b0}}, beat_gain});
  assign m_valid = v2;
  assign m_last  = l2;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_t lane_in;
    assign lane_in = s_data[k*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (adv1 && s_valid) prod1[k] <= lane_in * gain_s;
      if (adv2 && v1)      res2[k]  <= clamp_lane(prod1[k] >>> SHIFT);
    end

    assign m_data[k*LANE_W +: LANE_W] = res2[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      l1 <= 1'b0;
      v2 <= 1'b0;
      l2 <= 1'b0;
    end else begin
      if (adv1) begin
        v1 <= s_valid;
        if (s_valid) l1 <= s_last;
      end
      if (adv2) begin
        v2 <= v1;
        if (v1) l2 <= l1;
      end
    end
  end
endmodule

// File: rtl/iq_gain_stage.sv
module iq_gain_stage
  import iqg_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned CTX_W      = 64,
  parameter int unsigned GAIN_W     = 15,
  parameter int unsigned GAIN_RESET = 1,
  parameter int unsigned SHIFT      = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_req_wr,
  input  logic              ctl_req_rd,
  input  logic [ADDR_W-1:0] ctl_req_addr,
  input  logic [31:0]       ctl_req_data,
  output logic              ctl_resp_ack,
  output logic [31:0]       ctl_resp_data,
  input  logic [31:0]       s_pl_tdata,
  input  logic              s_pl_tlast,
  input  logic              s_pl_tvalid,
  output logic              s_pl_tready,
  output logic [31:0]       m_pl_tdata,
  output logic              m_pl_tlast,
  output logic              m_pl_tvalid,
  input  logic              m_pl_tready,
  input  logic [CTX_W-1:0]  s_cx_tdata,
  input  logic              s_cx_tlast,
  input  logic              s_cx_tvalid,
  output logic              s_cx_tready,
  output logic [CTX_W-1:0]  m_cx_tdata,
  output logic              m_cx_tlast,
  output logic              m_cx_tvalid,
  input  logic              m_cx_tready
);
  logic [GAIN_W-1:0] gain_reg;
  logic [GAIN_W-1:0] beat_gain;
  logic              in_fire;

  assign in_fire = s_pl_tvalid && s_pl_tready;

  // Context words pass through untouched.
  assign m_cx_tdata  = s_cx_tdata;
  assign m_cx_tlast  = s_cx_tlast;
  assign m_cx_tvalid = s_cx_tvalid;
  assign s_cx_tready = m_cx_tready;

  iqg_ctrl_regs #(
    .ADDR_W(ADDR_W), .GAIN_W(GAIN_W), .GAIN_ADDR(0), .GAIN_RESET(GAIN_RESET)
  ) u_regs (
    .clk(clk), .rst(rst),
    .req_wr(ctl_req_wr), .req_rd(ctl_req_rd),
    .req_addr(ctl_req_addr), .req_data(ctl_req_data),
    .resp_ack(ctl_resp_ack), .resp_data(ctl_resp_data),
    .gain_q(gain_reg)
  );

  iqg_pkt_gain #(.GAIN_W(GAIN_W)) u_pkt (
    .clk(clk), .rst(rst),
    .beat_fire(in_fire), .beat_last(s_pl_tlast),
    .reg_gain(gain_reg), .beat_gain(beat_gain)
  );

  iqg_mult_pipe #(.GAIN_W(GAIN_W), .SHIFT(SHIFT)) u_pipe (
    .clk(clk), .rst(rst),
    .s_data(s_pl_tdata), .s_last(s_pl_tlast),
    .s_valid(s_pl_tvalid), .s_ready(s_pl_tready),
    .beat_gain(beat_gain),
    .m_data(m_pl_tdata), .m_last(m_pl_tlast),
    .m_valid(m_pl_tvalid), .m_ready(m_pl_tready)
  );
endmodule

// File: rtl/iqg_checker.sv
module iqg_checker #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned GAIN_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_wr,
  input logic              ctl_rd,
  input logic [ADDR_W-1:0] ctl_addr,
  input logic              ctl_ack,
  input logic [31:0]       ctl_rdata,
  input logic [31:0]       m_data,
  input logic              m_last,
  input logic              m_valid,
  input logic              m_ready,
  input logic [GAIN_W-1:0] gain_reg
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  // R5
  ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr || ctl_rd) |=> ctl_ack);

  // R5
  ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl_wr || ctl_rd) |=> !ctl_ack);

  // R6
  undecoded_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_rd && ctl_addr != '0) |=> (ctl_rdata == '0));

  // R6
  undecoded_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_addr != '0) |=> $stable(gain_reg));
endmodule

bind iq_gain_stage iqg_checker #(.ADDR_W(ADDR_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst(rst),
  .ctl_wr(ctl_req_wr), .ctl_rd(ctl_req_rd), .ctl_addr(ctl_req_addr),
  .ctl_ack(ctl_resp_ack), .ctl_rdata(ctl_resp_data),
  .m_data(m_pl_tdata), .m_last(m_pl_tlast),
  .m_valid(m_pl_tvalid), .m_ready(m_pl_tready),
  .gain_reg(gain_reg)
);

// File: tb/iq_gain_stage_bench.sv
`timescale 1ns/1ps
module iq_gain_stage_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_req_wr = 1'b0, ctl_req_rd = 1'b0;
  logic [19:0] ctl_req_addr = '0;
  logic [31:0] ctl_req_data = '0;
  logic        ctl_resp_ack;
  logic [31:0] ctl_resp_data;
  logic [31:0] s_pl_tdata = '0;
  logic        s_pl_tlast = 1'b0, s_pl_tvalid = 1'b0, s_pl_tready;
  logic [31:0] m_pl_tdata;
  logic        m_pl_tlast, m_pl_tvalid, m_pl_tready = 1'b1;
  logic [63:0] s_cx_tdata = '0, m_cx_tdata;
  logic        s_cx_tlast = 1'b0, s_cx_tvalid = 1'b0, s_cx_tready;
  logic        m_cx_tlast, m_cx_tvalid, m_cx_tready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int sink_mode = 0;  // 0: always ready, 1: random stalls

  always #10 clk = ~clk;

  iq_gain_stage u_iq_gain_stage (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [32:0] exp_q[$];
  int  gain_m = 1;
  bit  in_pkt_m = 0;
  int  pkt_gain_m = 0;
  bit  exp_ack = 0;
  logic [31:0] exp_rdata = '0;
  string rd_tag = "R4";
  bit  prev_stall = 0;
  logic [32:0] prev_out = '0;

  function automatic int clamp16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [31:0] scale(input logic [31:0] d, input int g);
    int i, q;
    i = clamp16(int'($signed(d[31:16])) * g);
    q = clamp16(int'($signed(d[15:0])) * g);
    return {i[15:0], q[15:0]};
  endfunction

  initial begin : model
    forever begin
      @(negedge clk); #8;
      if (rst) begin
        exp_q.delete();
        gain_m = 1; in_pkt_m = 0; exp_ack = 0; prev_stall = 0;
      end else begin
        // R8 context passthrough
        check(m_cx_tdata == s_cx_tdata && m_cx_tlast == s_cx_tlast &&
              m_cx_tvalid == s_cx_tvalid && s_cx_tready == m_cx_tready,
              "R8", "context passthrough", longint'(m_cx_tdata), longint'(s_cx_tdata));
        // R3 stall hold
        if (prev_stall)
          check(m_pl_tvalid && {m_pl_tlast, m_pl_tdata} == prev_out, "R3",
                "stalled beat changed", longint'({m_pl_tlast, m_pl_tdata}), longint'(prev_out));
        prev_stall = m_pl_tvalid && !m_pl_tready;
        prev_out = {m_pl_tlast, m_pl_tdata};
        // R5 / R4 / R6 control response
        check(ctl_resp_ack == exp_ack, "R5", "ack", ctl_resp_ack, exp_ack);
        if (exp_ack)
          check(ctl_resp_data == exp_rdata, rd_tag, "read data", ctl_resp_data, exp_rdata);
        // output beat
        if (m_pl_tvalid && m_pl_tready) begin
          if (exp_q.size() == 0)
            check(0, "R2", "unexpected output beat", longint'(m_pl_tdata), 0);
          else begin
            logic [32:0] e;
            e = exp_q.pop_front();
            check(m_pl_tdata == e[31:0], "R1/R7", "scaled sample", m_pl_tdata, e[31:0]);
            check(m_pl_tlast == e[32], "R2", "tlast", m_pl_tlast, e[32]);
          end
        end
        // input beat uses gain before this cycle's write (R7)
        if (s_pl_tvalid && s_pl_tready) begin
          int g;
          g = in_pkt_m ? pkt_gain_m : gain_m;
          pkt_gain_m = g;
          in_pkt_m = !s_pl_tlast;
          exp_q.push_back({s_pl_tlast, scale(s_pl_tdata, g)});
        end
        // control request
        exp_ack = ctl_req_wr || ctl_req_rd;
        exp_rdata = '0;
        rd_tag = (ctl_req_addr == 0) ? "R4" : "R6";
        if (ctl_req_rd && ctl_req_addr == 0) exp_rdata = 32'(gain_m);
        if (ctl_req_wr && ctl_req_addr == 0) gain_m = int'(ctl_req_data[14:0]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic ctl_op(input logic w, input logic r, input logic [19:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    ctl_req_wr = w; ctl_req_rd = r; ctl_req_addr = a; ctl_req_data = d;
    @(negedge clk);
    ctl_req_wr = 1'b0; ctl_req_rd = 1'b0;
  endtask

  task automatic send_beat(input logic [31:0] d, input logic l, input bit gaps);
    @(negedge clk);
    if (gaps && ($urandom % 3 == 0)) begin
      s_pl_tvalid = 1'b0;
      @(negedge clk);
    end
    s_pl_tvalid = 1'b1; s_pl_tdata = d; s_pl_tlast = l;
    #8;
    while (!s_pl_tready) begin
      @(negedge clk); #8;
    end
  endtask

  task automatic send_pkt(input logic [31:0] beats[$], input bit gaps);
    foreach (beats[i]) send_beat(beats[i], i == beats.size() - 1, gaps);
    @(negedge clk);
    s_pl_tvalid = 1'b0; s_pl_tlast = 1'b0;
  endtask

  task automatic send_rand_pkt(input int len, input bit gaps);
    logic [31:0] b[$];
    for (int i = 0; i < len; i++) b.push_back($urandom);
    send_pkt(b, gaps);
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
  endtask

  // sink ready and context traffic
  initial begin
    forever begin
      @(negedge clk);
      m_pl_tready = (sink_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
      m_cx_tready = $urandom % 2;
      s_cx_tvalid = $urandom % 2;
      s_cx_tlast  = $urandom % 2;
      s_cx_tdata  = {$urandom, $urandom};
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  // ---------------- test sequence ----------------
  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #8;
    check(m_pl_tvalid == 1'b0, "R2", "output valid after reset", m_pl_tvalid, 0);
    check(s_pl_tready == 1'b1, "R3", "input ready after reset", s_pl_tready, 1);
    check(ctl_resp_ack == 1'b0, "R5", "ack after reset", ctl_resp_ack, 0);

    // R4 reset value 1
    ctl_op(0, 1, 20'h0, 0);
    // R1 gain 1, extreme values
    send_pkt('{32'h8000_7FFF, 32'h0000_0000, 32'h04D2_FFFB}, 0);
    drain();
    // R1 gain 2 saturation both ways
    ctl_op(1, 0, 20'h0, 32'd2);
    send_pkt('{32'h4E20_B1E0, 32'h3FFF_C000, 32'hBFFF_4000}, 0);
    drain();
    // R1 gain 0
    ctl_op(1, 0, 20'h0, 32'd0);
    send_pkt('{32'h1234_8765, 32'h7FFF_8000}, 0);
    drain();
    // R4 upper write bits dropped, read back 32767
    ctl_op(1, 0, 20'h0, 32'hFFFF_FFFF);
    ctl_op(0, 1, 20'h0, 0);
    send_pkt('{32'h0001_FFFF, 32'h0002_FFFE, 32'hFFFE_0000}, 0);
    drain();
    // R6 undecoded addresses
    ctl_op(1, 0, 20'h4, 32'd9);
    ctl_op(0, 1, 20'h4, 0);
    ctl_op(1, 0, 20'h80000, 32'd3);
    ctl_op(0, 1, 20'hFFFFC, 0);
    ctl_op(0, 1, 20'h0, 0);
    send_pkt('{32'h0001_0001}, 0);
    drain();

    // R7 write mid-packet with stalls
    ctl_op(1, 0, 20'h0, 32'd5);
    sink_mode = 1;
    fork
      send_rand_pkt(8, 1);
      begin repeat (4) @(negedge clk); ctl_op(1, 0, 20'h0, 32'd7); end
    join
    send_rand_pkt(4, 1);
    sink_mode = 0;
    drain();

    // R7 write in the same cycle as a packet's first beat
    fork
      ctl_op(1, 0, 20'h0, 32'd9);
      send_rand_pkt(3, 0);
    join
    send_rand_pkt(3, 0);
    drain();

    // stress with random stalls, gaps and gain changes
    sink_mode = 1;
    fork
      for (int p = 0; p < 40; p++) send_rand_pkt(1 + $urandom % 6, 1);
      for (int w = 0; w < 12; w++) begin
        repeat (5 + $urandom % 30) @(negedge clk);
        ctl_op(1, 0, ($urandom % 4 == 0) ? 20'h8 : 20'h0, $urandom);
      end
    join
    sink_mode = 0;
    drain();

    // R2 pipeline fully drained, nothing lost
    check(exp_q.size() == 0, "R2", "beats still expected", exp_q.size(), 0);
    check(m_pl_tvalid == 1'b0, "R2", "output idle after drain", m_pl_tvalid, 0);
    finish_run();
  end
endmodule